// File: doc/BRIEF.md
# Lock-Byte Access Guard

This block keeps the protection byte of an on-chip code and data store and turns it into permit signals for the rest of the chip. A program command can only move stored bits from 1 (open) to 0 (locked). The only way back to 1 is a chip-erase pulse, which returns the whole byte to the open state in one cycle. The flash array, the programming protocols and the processor core are outside the block. They read the permit outputs and the byte itself through the read-back port.

The low two bits form the memory protection field. It acts as a three-state protection level and controls external programming, external verify, fuse writes and writes of the boot protection bits. These permits apply to every external programming path alike.

Bits 3:2 form the boot protection field. It controls self-programming writes into the application area, table reads of the application area by boot code, and the interrupt mask for application code when the vectors live in the boot area.

Bits 5:4 are a second boot field. This block stores it and guards it but does not decode it. Bits 7:6 always read 1.

The memory protection field is decoded into a level:
- States: `ML_OPEN` (11), `ML_NOPROG` (10) and `ML_FULL` (00 or 01).
- Program transitions only go toward a stricter level: `ML_OPEN`→`ML_NOPROG`, `ML_OPEN`→`ML_FULL` and `ML_NOPROG`→`ML_FULL`.
- Erase transitions return every level to `ML_OPEN`.

The boot field decodes to `BL_FREE` (11), `BL_NOWRITE` (10), `BL_NOBOTH` (00) and `BL_NOREAD` (01).

Top module: `lockbit_guard`

## Requirements
- R1: `lock_rd[7:6]` always reads 11, whatever was programmed. `lock_rd[5:0]` returns the six stored bits.
- R2: After reset the byte reads 8'hFF. A program command (`prog_we`=1) replaces bits 5:0 with `stored & prog_data[5:0]`, so no bit ever returns from 0 to 1 through a program command.
- R3: A `chip_erase` pulse sets the byte to 8'hFF at the next clock edge. It takes priority over a program command in the same cycle.
- R4: Memory protection field `lock_rd[1:0]`, where 11 is open, 10 is no-program and 00 or 01 is full lock:
  - In the open level, `ext_prog_ok`, `ext_verify_ok`, `fuse_wr_ok` and `boot_lock_wr_ok` are all 1.
  - In the no-program level, `ext_prog_ok` and `fuse_wr_ok` are 0, while `ext_verify_ok` and `boot_lock_wr_ok` stay 1.
  - In the full-lock level, all four are 0.
- R5: In the full-lock level, a program command that would change any of bits 5:2 is ignored as a whole. A command that changes only bits 1:0 still applies.
- R6: `app_selfwr_ok` equals `lock_rd[2]`, so it is 1 in boot modes 11 and 01 and 0 in modes 10 and 00.
- R7: `boot_app_rd_ok` equals `lock_rd[3]`, so it is 1 in boot modes 11 and 10 and 0 in modes 00 and 01.
- R8: `app_irq_ok` is 0 exactly when `ivec_in_boot` is 1 and `lock_rd[3]` is 0.
- R9: The permits follow the stored byte. A program command changes them only after the clock edge that stores it, never in the cycle in which the command is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the byte returns to 8'hFF |
| prog_we | input | 1 | Program command strobe |
| prog_data | input | 8 | Program value; 0 bits lock, 1 bits keep |
| chip_erase | input | 1 | Erase pulse; sets the byte to all ones |
| ivec_in_boot | input | 1 | Interrupt vectors are placed in the boot area |
| lock_rd | output | 8 | Read-back of the protection byte |
| ext_prog_ok | output | 1 | External programming allowed |
| ext_verify_ok | output | 1 | External verify allowed |
| fuse_wr_ok | output | 1 | Fuse writes allowed |
| boot_lock_wr_ok | output | 1 | Writes of bits 5:2 allowed |
| app_selfwr_ok | output | 1 | Self-programming of the application area allowed |
| boot_app_rd_ok | output | 1 | Boot-code table reads of the application area allowed |
| app_irq_ok | output | 1 | Interrupts allowed while application code runs |

## Verification
The assertions check four things on every cycle:
- Bits 7:6 stay set and bits only fall outside an erase.
- An erase always yields all ones.
- The boot bits hold still under full lock.
- The permits stay consistent with the read-back byte.

Only the bench's scenarios can show the rest:
- An erase beats a simultaneous program command.
- The 01 memory encoding behaves as full lock.
- A rejected command leaves the byte unchanged, while a command touching only bits 1:0 still applies.
- The permits do not move before the storing edge.

// File: rtl/lockbit_pkg.sv
package lockbit_pkg;
    localparam int BYTE_W   = 8;
    localparam int LOCK_W   = 6;
    localparam int ML_LO    = 0;
    localparam int BL_LO    = 2;
    localparam int GUARD_LO = 2;

    typedef enum logic [1:0] {
        ML_OPEN,
        ML_NOPROG,
        ML_FULL
    } ml_mode_e;

    typedef enum logic [1:0] {
        BL_FREE,
        BL_NOWRITE,
        BL_NOREAD,
        BL_NOBOTH
    } bl_mode_e;
endpackage

// File: rtl/lock_store.sv
module lock_store
    import lockbit_pkg::*;
#(
    parameter int STORE_W = LOCK_W,
    parameter int OUT_W   = BYTE_W,
    parameter int GRD_LO  = GUARD_LO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [OUT_W-1:0]   prog_data,
    input  logic               chip_erase,
    input  logic               guard_open,
    output logic [OUT_W-1:0]   byte_rd
);
    localparam int PAD_W = OUT_W - STORE_W;

    logic [STORE_W-1:0] stored_q;
    logic [STORE_W-1:0] cand;
    logic               guard_hit;
    logic               unused_hi;

    assign unused_hi = ^prog_data[OUT_W-1:STORE_W];
    assign cand      = stored_q & prog_data[STORE_W-1:0];
    assign guard_hit = !guard_open &&
                       (cand[STORE_W-1:GRD_LO] != stored_q[STORE_W-1:GRD_LO]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '1;
        end else if (chip_erase) begin
            stored_q <= '1;
        end else if (prog_we && !guard_hit) begin
            stored_q <= cand;
        end
    end

    assign byte_rd = {{PAD_W{1'b1}}, stored_q};
endmodule

// File: rtl/mem_lock_decode.sv
module mem_lock_decode
    import lockbit_pkg::*;
(
    input  logic [1:0] ml_field,
    output ml_mode_e   ml_mode,
    output logic       ext_prog_ok,
    output logic       ext_verify_ok,
    output logic       fuse_wr_ok,
    output logic       boot_lock_wr_ok
);
    always_comb begin
        unique case (ml_field)
            2'b11:   ml_mode = ML_OPEN;
            2'b10:   ml_mode = ML_NOPROG;
            default: ml_mode = ML_FULL;
        endcase
    end

    always_comb begin
        ext_prog_ok     = 1'b0;
        ext_verify_ok   = 1'b0;
        fuse_wr_ok      = 1'b0;
        boot_lock_wr_ok = 1'b0;
        unique case (ml_mode)
            ML_OPEN: begin
                ext_prog_ok     = 1'b1;
                ext_verify_ok   = 1'b1;
                fuse_wr_ok      = 1'b1;
                boot_lock_wr_ok = 1'b1;
            end
            ML_NOPROG: begin
                ext_verify_ok   = 1'b1;
                boot_lock_wr_ok = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/boot_lock_decode.sv
module boot_lock_decode
    import lockbit_pkg::*;
(
    input  logic [1:0] bl_field,
    input  logic       ivec_in_boot,
    output bl_mode_e   bl_mode,
    output logic       app_selfwr_ok,
    output logic       boot_app_rd_ok,
    output logic       app_irq_ok
);
    always_comb begin
        unique case (bl_field)
            2'b11:   bl_mode = BL_FREE;
            2'b10:   bl_mode = BL_NOWRITE;
            2'b01:   bl_mode = BL_NOREAD;
            default: bl_mode = BL_NOBOTH;
        endcase
    end

    always_comb begin
        app_selfwr_ok  = 1'b1;
        boot_app_rd_ok = 1'b1;
        unique case (bl_mode)
            BL_FREE: begin
            end
            BL_NOWRITE: app_selfwr_ok = 1'b0;
            BL_NOREAD:  boot_app_rd_ok = 1'b0;
            default: begin
                app_selfwr_ok  = 1'b0;
                boot_app_rd_ok = 1'b0;
            end
        endcase
        app_irq_ok = !(ivec_in_boot && !boot_app_rd_ok);
    end
endmodule

// File: rtl/lockbit_guard.sv
module lockbit_guard
    import lockbit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        prog_we,
    input  logic [7:0]  prog_data,
    input  logic        chip_erase,
    input  logic        ivec_in_boot,
    output logic [7:0]  lock_rd,
    output logic        ext_prog_ok,
    output logic        ext_verify_ok,
    output logic        fuse_wr_ok,
    output logic        boot_lock_wr_ok,
    output logic        app_selfwr_ok,
    output logic        boot_app_rd_ok,
    output logic        app_irq_ok
);
    ml_mode_e ml_mode;
    bl_mode_e bl_mode;
    logic     unused_modes;

    assign unused_modes = ^{ml_mode, bl_mode};

    lock_store #(
        .STORE_W (LOCK_W),
        .OUT_W   (BYTE_W),
        .GRD_LO  (GUARD_LO)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_we    (prog_we),
        .prog_data  (prog_data),
        .chip_erase (chip_erase),
        .guard_open (boot_lock_wr_ok),
        .byte_rd    (lock_rd)
    );

    mem_lock_decode u_mdec (
        .ml_field        (lock_rd[ML_LO+1:ML_LO]),
        .ml_mode         (ml_mode),
        .ext_prog_ok     (ext_prog_ok),
        .ext_verify_ok   (ext_verify_ok),
        .fuse_wr_ok      (fuse_wr_ok),
        .boot_lock_wr_ok (boot_lock_wr_ok)
    );

    boot_lock_decode u_bdec (
        .bl_field       (lock_rd[BL_LO+1:BL_LO]),
        .ivec_in_boot   (ivec_in_boot),
        .bl_mode        (bl_mode),
        .app_selfwr_ok  (app_selfwr_ok),
        .boot_app_rd_ok (boot_app_rd_ok),
        .app_irq_ok     (app_irq_ok)
    );
endmodule

// File: rtl/lockbit_guard_chk.sv
module lockbit_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       prog_we,
    input logic       chip_erase,
    input logic       ivec_in_boot,
    input logic [7:0] lock_rd,
    input logic       ext_prog_ok,
    input logic       ext_verify_ok,
    input logic       fuse_wr_ok,
    input logic       boot_lock_wr_ok,
    input logic       app_selfwr_ok,
    input logic       boot_app_rd_ok,
    input logic       app_irq_ok
);
    // R1
    pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_rd[7:6] == 2'b11);

    // R2
    one_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_erase |=> ((lock_rd & ~$past(lock_rd)) == 8'h00));

    // R3
    erase_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase |=> lock_rd == 8'hFF);

    // R4
    prog_implies_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_prog_ok |-> (ext_verify_ok && fuse_wr_ok && boot_lock_wr_ok));

    // R4
    full_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_rd[1] |-> !(ext_prog_ok || ext_verify_ok || fuse_wr_ok || boot_lock_wr_ok));

    // R5
    boot_bits_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_rd[1] && prog_we && !chip_erase) |=> $stable(lock_rd[5:2]));

    // R6
    selfwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        app_selfwr_ok == lock_rd[2]);

    // R7
    bootrd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_app_rd_ok == lock_rd[3]);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ivec_in_boot && !lock_rd[3]) |-> !app_irq_ok);
endmodule

bind lockbit_guard lockbit_guard_chk u_chk (.*);

// File: tb/lockbit_guard_bench.sv
module lockbit_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_we = 1'b0;
    logic [7:0] prog_data = 8'hFF;
    logic       chip_erase = 1'b0;
    logic       ivec_in_boot = 1'b0;
    logic [7:0] lock_rd;
    logic       ext_prog_ok, ext_verify_ok, fuse_wr_ok, boot_lock_wr_ok;
    logic       app_selfwr_ok, boot_app_rd_ok, app_irq_ok;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'hFF;
    logic [14:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    lockbit_guard u_lockbit_guard (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_data(prog_data),
        .chip_erase(chip_erase), .ivec_in_boot(ivec_in_boot), .lock_rd(lock_rd),
        .ext_prog_ok(ext_prog_ok), .ext_verify_ok(ext_verify_ok),
        .fuse_wr_ok(fuse_wr_ok), .boot_lock_wr_ok(boot_lock_wr_ok),
        .app_selfwr_ok(app_selfwr_ok), .boot_app_rd_ok(boot_app_rd_ok),
        .app_irq_ok(app_irq_ok)
    );

    function automatic logic [14:0] predict(input logic [7:0] m, input logic iv);
        logic open_l, full_l;
        open_l = m[1] & m[0];
        full_l = !m[1];
        return {m, open_l, !full_l, open_l, !full_l, m[2], m[3], !(iv && !m[3])};
    endfunction

    function automatic logic [14:0] observed();
        return {lock_rd, ext_prog_ok, ext_verify_ok, fuse_wr_ok, boot_lock_wr_ok,
                app_selfwr_ok, boot_app_rd_ok, app_irq_ok};
    endfunction

    task automatic compare(input string tag, input logic [14:0] act, input logic [14:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic op(input logic we, input logic [7:0] d, input logic er,
                      input logic iv, input string tag, input bit pre_chk);
        logic [7:0] cand;
        @(negedge clk);
        prog_we = we; prog_data = d; chip_erase = er; ivec_in_boot = iv;
        if (pre_chk) begin
            #1;
            compare({tag, " before edge"}, observed(), predict(model, iv));
        end
        if (er) model = 8'hFF;
        else if (we) begin
            cand = model & {2'b11, d[5:0]};
            if (!(model[1] == 1'b0 && cand[5:2] != model[5:2])) model = cand;
        end
        exp_q.push_back(predict(model, iv));
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expectation per edge after the update settles
    always @(posedge clk) begin
        if (exp_q.size() > 0) begin
            #1;
            compare(tag_q.pop_front(), observed(), exp_q.pop_front());
        end
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R2 reset", observed(), predict(8'hFF, 1'b0));
        op(0, 8'h00, 0, 0, "R2 idle ignores data", 0);
        op(1, 8'hFE, 0, 0, "R4 no-program level", 1);
        op(1, 8'hFF, 0, 0, "R2 ones keep state", 0);
        op(1, 8'hFB, 0, 0, "R6 boot 10 blocks self write", 1);
        op(0, 8'hFF, 0, 1, "R8 vectors in boot, reads open", 0);
        op(1, 8'h00, 1, 0, "R3 erase beats program", 0);
        op(1, 8'hF3, 0, 1, "R7 R8 boot 00 masks", 0);
        op(0, 8'hFF, 1, 0, "R3 erase", 0);
        op(1, 8'hF7, 0, 0, "R6 R7 boot 01", 0);
        op(1, 8'hFC, 0, 0, "R4 full level", 1);
        op(1, 8'hEF, 0, 0, "R5 boot change rejected", 0);
        op(1, 8'hFF, 0, 0, "R5 no-change accepted", 0);
        op(0, 8'hFF, 1, 0, "R3 erase again", 0);
        op(1, 8'hFD, 0, 0, "R4 encoding 01 is full", 0);
        op(1, 8'hF8, 0, 0, "R5 mixed change rejected", 0);
        op(1, 8'hFC, 0, 0, "R5 low-bit clear applies", 0);
        op(0, 8'hFF, 1, 0, "R3 erase restores", 0);
        op(1, 8'h3F, 0, 0, "R1 pad bits stay one", 0);
        op(1, 8'h0D, 0, 1, "R1 R8 mixed program", 0);
        op(0, 8'hFF, 0, 0, "R9 steady", 0);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule